// File: doc/BRIEF.md
# Small-Format Floating-Point Adder

This block adds two floating-point numbers held in a very small, width-parameterized format. A word is a sign, an exponent field of `EXP_W` bits and a fraction field of `FRAC_W` bits. The block unpacks both operands and lines up the smaller one against the larger. It then adds or subtracts the two significands, renormalizes the outcome and packs it back into the same format. The result is registered one cycle after a valid strobe.

A mode pin picks how the zero exponent code is treated. In gradual mode that code marks a subnormal value whose significand has no hidden one. In flush mode that code is read as zero on the way in, and a result too small to be normal leaves the block as zero. The all-ones exponent code is never a number. An operand that carries it raises the invalid flag. A sum whose exponent would grow into it saturates there and raises the overflow flag. Alignment drops the bits of the smaller operand that fall off the end, with no guard or sticky bits, so small addends can vanish entirely.

Top module: `minifloat_adder`

## Requirements
- R1: A word is {sign at the MSB, exponent field of EXP_W bits, fraction field of FRAC_W bits at the LSBs}. With the exponent field E nonzero and not all ones, the value is (-1)^sign × 1.fraction × 2^(E − (2^(EXP_W−1) − 1)). Two such operands produce their sum in the same encoding.
- R2: During alignment the smaller operand's significand is shifted right by the exponent difference, and bits shifted out are discarded. There is no rounding, so with defaults 1.25 + 2.0 gives 3.0 and 3.5 + 0.25 gives 3.5.
- R3: If the result exponent would reach the all-ones code, the output is {sign of result, all-ones exponent, zero fraction} and `overflow` is 1.
- R4: If either operand has an all-ones exponent field, the output is {0, all-ones exponent, zero fraction}, `invalid` is 1 and `overflow` is 0.
- R5: With `flush_mode`=0, exponent field 0 means the value 0.fraction × 2^(2 − 2^(EXP_W−1)). Sums below the smallest normal are emitted with exponent field 0. Subnormal sums that carry into the hidden bit become normal with exponent field 1.
- R6: With `flush_mode`=1, any operand with exponent field 0 counts as zero, whatever its fraction.
- R7: With `flush_mode`=1, a nonzero result below the smallest normal is output as zero with the result's sign kept: exponent field 0 and fraction 0.
- R8: A sum whose magnitude is exactly zero, other than the flush case of R7, is output as positive zero (all bits 0).
- R9: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid`=1. When `in_valid` is 0, `sum_out`, `overflow` and `invalid` keep their values.
- R10: After reset, `out_valid`, `sum_out`, `overflow` and `invalid` are all 0.
- R11: When a subtraction leaves leading zeros, the significand is shifted left and the exponent lowered. The shift stops at the smallest normal exponent, so that 2.0 − 1.5 gives the subnormal 0.5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| flush_mode | input | 1 | 1 = zero exponent flushed to zero, 0 = gradual underflow |
| op_a | input | 1+EXP_W+FRAC_W | First operand |
| op_b | input | 1+EXP_W+FRAC_W | Second operand |
| out_valid | output | 1 | Result registered from the previous cycle's operands |
| sum_out | output | 1+EXP_W+FRAC_W | Packed sum |
| overflow | output | 1 | Result saturated to the all-ones exponent |
| invalid | output | 1 | An operand carried the all-ones exponent |

## Verification
There is only one register stage, so a fault in the decode, alignment or normalization logic shows on `sum_out` in the very cycle after the strobe that carried the operands. A faulty alignment shift makes a result differ from the truncated value in its low fraction bits. A faulty normalization limit shows up as a wrong exponent on small differences, for example a normal code where a subnormal is due. A fault in the result classifier shows as a wrong flag or a wrong packed class: a nonzero subnormal surviving flush mode, negative zero after cancellation, or a missing flag on the all-ones exponent.

// File: rtl/mfadd_pkg.sv
package mfadd_pkg;
    // Class of a packed result, decided after normalization
    typedef enum logic [2:0] {
        RC_ZERO,
        RC_SUB,
        RC_NORM,
        RC_OVF,
        RC_BAD
    } res_class_e;
endpackage

// File: rtl/mf_unpack.sv
module mf_unpack #(
    parameter int EW = 2,
    parameter int FW = 2
) (
    input  logic [EW+FW:0] word_i,
    input  logic           flush_i,
    output logic           sign_o,
    output logic [EW-1:0]  eexp_o,
    output logic [FW:0]    sig_o,
    output logic           reserved_o
);
    logic [EW-1:0] efield;
    logic [FW-1:0] ffield;

    assign sign_o = word_i[EW+FW];
    assign efield = word_i[FW +: EW];
    assign ffield = word_i[FW-1:0];

    always_comb begin
        reserved_o = &efield;
        if (efield == '0) begin
            // zero code sits on the scale of the smallest normal interval
            eexp_o = EW'(1);
            sig_o  = flush_i ? '0 : {1'b0, ffield};
        end else begin
            eexp_o = efield;
            sig_o  = {1'b1, ffield};
        end
    end
endmodule

// File: rtl/mf_addcore.sv
module mf_addcore #(
    parameter int EW = 2,
    parameter int FW = 2
) (
    input  logic          sign_a_i,
    input  logic [EW-1:0] eexp_a_i,
    input  logic [FW:0]   sig_a_i,
    input  logic          sign_b_i,
    input  logic [EW-1:0] eexp_b_i,
    input  logic [FW:0]   sig_b_i,
    output logic          sign_o,
    output logic [EW:0]   exp_o,
    output logic [FW:0]   sig_o,
    output logic          zero_o
);
    localparam int SW = FW + 2;

    logic          swap;
    logic          sign_big;
    logic [EW-1:0] exp_big;
    logic [EW-1:0] exp_small;
    logic [FW:0]   sig_big;
    logic [FW:0]   sig_small;
    logic [EW-1:0] exp_diff;
    logic [FW:0]   sig_aligned;
    logic [SW-1:0] raw_sum;
    int            lead_zeros;
    int            shift_limit;
    int            shift_amt;
    logic          found;

    // larger magnitude first: effective exponent, then significand
    assign swap      = {eexp_b_i, sig_b_i} > {eexp_a_i, sig_a_i};
    assign sign_big  = swap ? sign_b_i : sign_a_i;
    assign exp_big   = swap ? eexp_b_i : eexp_a_i;
    assign exp_small = swap ? eexp_a_i : eexp_b_i;
    assign sig_big   = swap ? sig_b_i  : sig_a_i;
    assign sig_small = swap ? sig_a_i  : sig_b_i;

    // truncating alignment: bits shifted past the LSB are lost
    assign exp_diff    = exp_big - exp_small;
    assign sig_aligned = sig_small >> exp_diff;

    always_comb begin
        if (sign_a_i ^ sign_b_i)
            raw_sum = {1'b0, sig_big} - {1'b0, sig_aligned};
        else
            raw_sum = {1'b0, sig_big} + {1'b0, sig_aligned};
    end

    always_comb begin
        lead_zeros = FW + 1;
        found      = 1'b0;
        for (int i = FW; i >= 0; i--) begin
            if (raw_sum[i] && !found) begin
                lead_zeros = FW - i;
                found      = 1'b1;
            end
        end
        shift_limit = int'(exp_big) - 1;
        shift_amt   = (lead_zeros < shift_limit) ? lead_zeros : shift_limit;

        if (raw_sum[SW-1]) begin
            sig_o = raw_sum[SW-1:1];
            exp_o = {1'b0, exp_big} + (EW+1)'(1);
        end else begin
            sig_o = raw_sum[FW:0] << shift_amt;
            exp_o = {1'b0, exp_big - EW'(shift_amt)};
        end
        sign_o = sign_big;
        zero_o = (raw_sum == '0);
    end
endmodule

// File: rtl/mf_pack.sv
module mf_pack
    import mfadd_pkg::*;
#(
    parameter int EW = 2,
    parameter int FW = 2
) (
    input  logic           flush_i,
    input  logic           bad_i,
    input  logic           sign_i,
    input  logic [EW:0]    exp_i,
    input  logic [FW:0]    sig_i,
    input  logic           zero_i,
    output logic [EW+FW:0] word_o,
    output logic           ovf_o,
    output logic           inv_o
);
    localparam logic [EW:0] EXP_RSV = {1'b0, {EW{1'b1}}};

    res_class_e rclass;

    always_comb begin
        if (bad_i)
            rclass = RC_BAD;
        else if (zero_i)
            rclass = RC_ZERO;
        else if (exp_i >= EXP_RSV)
            rclass = RC_OVF;
        else if (!sig_i[FW])
            rclass = RC_SUB;
        else
            rclass = RC_NORM;
    end

    always_comb begin
        word_o = '0;
        ovf_o  = 1'b0;
        inv_o  = 1'b0;
        unique case (rclass)
            RC_BAD: begin
                word_o = {1'b0, {EW{1'b1}}, {FW{1'b0}}};
                inv_o  = 1'b1;
            end
            RC_ZERO: word_o = '0;
            RC_OVF: begin
                word_o = {sign_i, {EW{1'b1}}, {FW{1'b0}}};
                ovf_o  = 1'b1;
            end
            RC_SUB: begin
                if (flush_i)
                    word_o = {sign_i, {EW{1'b0}}, {FW{1'b0}}};
                else
                    word_o = {sign_i, {EW{1'b0}}, sig_i[FW-1:0]};
            end
            RC_NORM: word_o = {sign_i, exp_i[EW-1:0], sig_i[FW-1:0]};
            default: word_o = '0;
        endcase
    end
endmodule

// File: rtl/minifloat_adder.sv
module minifloat_adder #(
    parameter int EXP_W  = 2,
    parameter int FRAC_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    flush_mode,
    input  logic [EXP_W+FRAC_W:0]   op_a,
    input  logic [EXP_W+FRAC_W:0]   op_b,
    output logic                    out_valid,
    output logic [EXP_W+FRAC_W:0]   sum_out,
    output logic                    overflow,
    output logic                    invalid
);
    localparam int WW = 1 + EXP_W + FRAC_W;

    logic [WW-1:0]    ops      [2];
    logic             op_sign  [2];
    logic [EXP_W-1:0] op_eexp  [2];
    logic [FRAC_W:0]  op_sig   [2];
    logic             op_rsv   [2];

    logic             c_sign;
    logic [EXP_W:0]   c_exp;
    logic [FRAC_W:0]  c_sig;
    logic             c_zero;
    logic [WW-1:0]    packed_word;
    logic             packed_ovf;
    logic             packed_inv;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_unpack
        mf_unpack #(.EW(EXP_W), .FW(FRAC_W)) u_unpack (
            .word_i    (ops[g]),
            .flush_i   (flush_mode),
            .sign_o    (op_sign[g]),
            .eexp_o    (op_eexp[g]),
            .sig_o     (op_sig[g]),
            .reserved_o(op_rsv[g])
        );
    end

    mf_addcore #(.EW(EXP_W), .FW(FRAC_W)) u_core (
        .sign_a_i(op_sign[0]),
        .eexp_a_i(op_eexp[0]),
        .sig_a_i (op_sig[0]),
        .sign_b_i(op_sign[1]),
        .eexp_b_i(op_eexp[1]),
        .sig_b_i (op_sig[1]),
        .sign_o  (c_sign),
        .exp_o   (c_exp),
        .sig_o   (c_sig),
        .zero_o  (c_zero)
    );

    mf_pack #(.EW(EXP_W), .FW(FRAC_W)) u_pack (
        .flush_i(flush_mode),
        .bad_i  (op_rsv[0] | op_rsv[1]),
        .sign_i (c_sign),
        .exp_i  (c_exp),
        .sig_i  (c_sig),
        .zero_i (c_zero),
        .word_o (packed_word),
        .ovf_o  (packed_ovf),
        .inv_o  (packed_inv)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum_out   <= '0;
            overflow  <= 1'b0;
            invalid   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum_out  <= packed_word;
                overflow <= packed_ovf;
                invalid  <= packed_inv;
            end
        end
    end
endmodule

// File: rtl/mfadd_checker.sv
module mfadd_checker #(
    parameter int EW = 2,
    parameter int FW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           flush_mode,
    input logic [EW+FW:0] op_a,
    input logic [EW+FW:0] op_b,
    input logic           out_valid,
    input logic [EW+FW:0] sum_out,
    input logic           overflow,
    input logic           invalid
);
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_out) && $stable(overflow) && $stable(invalid)));

    assert_ovf_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (&sum_out[FW +: EW] && sum_out[FW-1:0] == '0 && !invalid));

    assert_bad_operand_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&op_a[FW +: EW] || &op_b[FW +: EW])) |=>
        (invalid && !overflow && sum_out == {1'b0, {EW{1'b1}}, {FW{1'b0}}}));

    assert_no_sub_in_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flush_mode) |=>
        (sum_out[FW +: EW] != '0 || sum_out[FW-1:0] == '0));

    assert_positive_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush_mode) |=>
        !(sum_out[EW+FW-1:0] == '0 && sum_out[EW+FW]));
endmodule

bind minifloat_adder mfadd_checker #(.EW(EXP_W), .FW(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .flush_mode(flush_mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .sum_out   (sum_out),
    .overflow  (overflow),
    .invalid   (invalid)
);

// File: tb/sim_minifloat_adder.sv
`timescale 1ns/1ps
module sim_minifloat_adder;
    localparam int NV = 19;
    // {req[3:0], flush, a[4:0], b[4:0], expected sum[4:0], ovf, inv}
    localparam logic [21:0] VEC [NV] = '{
        {4'd1,  1'b0, 5'b00100, 5'b00100, 5'b01000, 1'b0, 1'b0}, // R1 1.0+1.0=2.0
        {4'd2,  1'b0, 5'b00101, 5'b01000, 5'b01010, 1'b0, 1'b0}, // R2 1.25+2.0 -> 3.0
        {4'd3,  1'b0, 5'b01001, 5'b00110, 5'b01100, 1'b1, 1'b0}, // R3 2.5+1.5 saturates
        {4'd2,  1'b0, 5'b01011, 5'b00001, 5'b01011, 1'b0, 1'b0}, // R2 3.5+0.25 -> 3.5
        {4'd5,  1'b0, 5'b00001, 5'b00010, 5'b00011, 1'b0, 1'b0}, // R5 0.25+0.5 subnormal
        {4'd5,  1'b0, 5'b00010, 5'b00010, 5'b00100, 1'b0, 1'b0}, // R5 0.5+0.5 -> 1.0
        {4'd5,  1'b0, 5'b10101, 5'b00100, 5'b10001, 1'b0, 1'b0}, // R5 -1.25+1.0 -> -0.25
        {4'd7,  1'b1, 5'b10101, 5'b00100, 5'b10000, 1'b0, 1'b0}, // R7 same, flushed, sign kept
        {4'd11, 1'b0, 5'b01000, 5'b10110, 5'b00010, 1'b0, 1'b0}, // R11 2.0-1.5 -> 0.5
        {4'd11, 1'b0, 5'b01010, 5'b11001, 5'b00010, 1'b0, 1'b0}, // R11 3.0-2.5 -> 0.5
        {4'd8,  1'b0, 5'b11001, 5'b01001, 5'b00000, 1'b0, 1'b0}, // R8 -2.5+2.5 -> +0
        {4'd4,  1'b0, 5'b01100, 5'b00100, 5'b01100, 1'b0, 1'b1}, // R4 a reserved
        {4'd6,  1'b1, 5'b00011, 5'b00100, 5'b00100, 1'b0, 1'b0}, // R6 0.75 read as 0
        {4'd5,  1'b0, 5'b00011, 5'b00100, 5'b00111, 1'b0, 1'b0}, // R5 0.75+1.0=1.75
        {4'd3,  1'b0, 5'b11011, 5'b11011, 5'b11100, 1'b1, 1'b0}, // R3 -3.5-3.5 saturates
        {4'd1,  1'b0, 5'b10100, 5'b10010, 5'b10110, 1'b0, 1'b0}, // R1 -1.0-0.5=-1.5
        {4'd7,  1'b1, 5'b00111, 5'b10110, 5'b00000, 1'b0, 1'b0}, // R7 1.75-1.5 flushed
        {4'd6,  1'b1, 5'b00010, 5'b10001, 5'b00000, 1'b0, 1'b0}, // R6 both read as 0
        {4'd4,  1'b0, 5'b00100, 5'b11111, 5'b01100, 1'b0, 1'b1}  // R4 b reserved
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       flush_mode = 1'b0;
    logic [4:0] op_a = '0;
    logic [4:0] op_b = '0;
    logic       out_valid;
    logic [4:0] sum_out;
    logic       overflow;
    logic       invalid;
    int         checks = 0;
    int         fails = 0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    minifloat_adder #(.EXP_W(2), .FRAC_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .flush_mode(flush_mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .sum_out(sum_out),
        .overflow(overflow), .invalid(invalid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 out_valid", 32'(out_valid), 32'd0);
        check("R10 sum_out", 32'(sum_out), 32'd0);
        check("R10 flags", 32'({overflow, invalid}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            flush_mode = VEC[i][17];
            op_a       = VEC[i][16:12];
            op_b       = VEC[i][11:7];
            in_valid   = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vec%0d sum", VEC[i][21:18], i), 32'(sum_out), 32'(VEC[i][6:2]));
            check($sformatf("R%0d vec%0d flags", VEC[i][21:18], i),
                  32'({overflow, invalid}), 32'(VEC[i][1:0]));
            check($sformatf("R9 vec%0d out_valid", i), 32'(out_valid), 32'd1);
        end
        // R9: idle cycle keeps the last result and drops valid
        in_valid   = 1'b0;
        flush_mode = 1'b0;
        op_a       = 5'b00100;
        op_b       = 5'b00100;
        @(negedge clk);
        check("R9 idle out_valid", 32'(out_valid), 32'd0);
        check("R9 idle sum held", 32'(sum_out), 32'h0C);
        check("R9 idle invalid held", 32'(invalid), 32'd1);
        // R9 strobe again: result appears one cycle later
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 new result", 32'(sum_out), 32'h08);
        check("R9 valid pulse", 32'(out_valid), 32'd1);
        @(negedge clk);
        check("R9 valid drops", 32'(out_valid), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule